// File: doc/BRIEF.md
# SPI flash instruction sequencer

This block turns one latched flash operation (a 3-bit operation code plus a sector and a page number) into the full series of serial flash transactions the operation needs. It drives chip select, the serial clock and the outgoing data line, and it samples the incoming data line through its own byte shift engine. Before any operation that modifies the flash, it issues a separate write-enable transaction of its own.

Outgoing page data comes from an external page buffer. The block presents a word index and reads the addressed 32-bit word back on the same cycle. A four-byte data read returns one packed word, and a status read returns one byte. Both stay on their outputs until the next operation of the same kind. A controller gives a one-cycle request, receives an accept pulse when the block leaves idle, and receives a done pulse when the last transaction ends.

The flash address is always {sector, page, 8'h00}. The serial clock period is CLK_DIV system clocks, where CLK_DIV is even and at least 2.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, accept and done are low, and the read word and status byte are zero.
- R2: The serial interface uses SPI mode 0. Bytes are sent MSB first, and each byte is 8 clock pulses. Each high phase of the serial clock lasts CLK_DIV/2 system clocks. The serial clock is low whenever chip select is high, and chip select stays low for every byte of a transaction.
- R3: Operation codes 001, 011 and 101 first run a one-byte transaction carrying 0x06. Chip select then stays high for at least one system clock before the main transaction starts.
- R4: Code 001 (sector erase) sends 0xD8, then sector, then page, then 0x00.
- R5: Code 010 (data read) sends 0x03 and the three address bytes. It then clocks four bytes while sending 0x00. The first received byte lands in rd_word bits 31-24, and the last lands in bits 7-0.
- R6: Code 011 (page program) sends 0x02 and the three address bytes, followed by 256 data bytes. These are buffer words 0 to 63 in order, with bits 31-24 of each word sent first.
- R7: Code 100 (status read) sends 0x05 and clocks one byte while sending 0x00. The received byte appears on status_byte.
- R8: Code 101 (status write) sends 0x01 and then the op_status_wr value that was present when the request was accepted.
- R9: Codes 000, 110 and 111 are ignored. A request with one of them gives a done pulse in the next cycle, with no accept pulse and no chip select activity.
- R10: A valid request seen in idle gives a one-cycle accept pulse in the next cycle. Done is a one-cycle pulse in the cycle where chip select returns high after the final transaction.
- R11: Requests made while an operation is in progress are ignored. They produce no accept pulse and no extra transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation code |
| op_page | input | 8 | Page number (address bits 15-8) |
| op_sector | input | 8 | Sector number (address bits 23-16) |
| op_status_wr | input | 8 | Byte for a status write |
| op_accept | output | 1 | Pulse when an operation starts |
| op_done | output | 1 | Pulse when an operation ends |
| wbuf_idx | output | 6 | Page buffer word index |
| wbuf_word | input | 32 | Page buffer word at wbuf_idx |
| rd_word | output | 32 | Packed result of a data read |
| status_byte | output | 8 | Result of a status read |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A responder on the serial pins records every byte of every transaction. It answers each byte position with a value derived from a per-operation seed, so a read placed in the wrong byte order, or taken from the wrong byte position, shows up at once. The bench sends random mixes of all eight codes with random sectors, pages, status values and buffer contents, including the reserved codes. Directed cases use address bytes 0x00 and 0xFF, which separate the sector byte from the page byte. A request is injected in the middle of a page program, which separates a busy block that ignores it from one that queues or restarts. Back-to-back operations show whether the block returns to idle cleanly after each done pulse.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  localparam int PAGE_BYTES = 256;
  localparam int READ_BYTES = 4;
  localparam int CNT_W      = $clog2(PAGE_BYTES + 5);
  localparam int OFS_W      = $clog2(PAGE_BYTES);
  localparam int BUF_AW     = $clog2(PAGE_BYTES / 4);

  localparam logic [2:0] CODE_ERASE = 3'd1;
  localparam logic [2:0] CODE_READ  = 3'd2;
  localparam logic [2:0] CODE_PROG  = 3'd3;
  localparam logic [2:0] CODE_RDST  = 3'd4;
  localparam logic [2:0] CODE_WRST  = 3'd5;

  localparam logic [7:0] INS_WREN   = 8'h06;
  localparam logic [7:0] INS_RDST   = 8'h05;
  localparam logic [7:0] INS_WRST   = 8'h01;
  localparam logic [7:0] INS_READ   = 8'h03;
  localparam logic [7:0] INS_PROG   = 8'h02;
  localparam logic [7:0] INS_SERASE = 8'hD8;

  // shape of one chip-select-low transaction
  typedef struct packed {
    logic [7:0]       inst;
    logic             has_addr;
    logic             src_buf;
    logic [CNT_W-1:0] n_out;
    logic [CNT_W-1:0] n_in;
  } xfer_plan_t;

  function automatic logic op_supported(input logic [2:0] c);
    return (c >= CODE_ERASE) && (c <= CODE_WRST);
  endfunction

  function automatic logic needs_wren(input logic [2:0] c);
    return (c == CODE_ERASE) || (c == CODE_PROG) || (c == CODE_WRST);
  endfunction

  function automatic xfer_plan_t wren_plan();
    xfer_plan_t p;
    p = '0;
    p.inst = INS_WREN;
    return p;
  endfunction

  function automatic xfer_plan_t main_plan(input logic [2:0] c);
    xfer_plan_t p;
    p = '0;
    case (c)
      CODE_ERASE: begin p.inst = INS_SERASE; p.has_addr = 1'b1; end
      CODE_READ:  begin p.inst = INS_READ; p.has_addr = 1'b1; p.n_in = CNT_W'(READ_BYTES); end
      CODE_PROG:  begin p.inst = INS_PROG; p.has_addr = 1'b1; p.src_buf = 1'b1;
                        p.n_out = CNT_W'(PAGE_BYTES); end
      CODE_RDST:  begin p.inst = INS_RDST; p.n_in = CNT_W'(1); end
      CODE_WRST:  begin p.inst = INS_WRST; p.n_out = CNT_W'(1); end
      default:    p.inst = INS_WREN;
    endcase
    return p;
  endfunction

  function automatic logic [23:0] flash_addr(input logic [7:0] sector, input logic [7:0] page);
    return {sector, page, 8'h00};
  endfunction

  function automatic logic [CNT_W-1:0] hdr_len(input logic has_addr);
    return has_addr ? CNT_W'(4) : CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] last_index(input xfer_plan_t p);
    return hdr_len(p.has_addr) + p.n_out + p.n_in - CNT_W'(1);
  endfunction
endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HALF = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh;
  logic          half_tick;

  assign half_tick = busy_o && (div_cnt == DW'(HALF - 1));
  assign mosi_o    = sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      sh      <= '0;
      sck_o   <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      rx_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o  <= 1'b1;
        sh      <= tx_i;
        bit_cnt <= '0;
        div_cnt <= '0;
        sck_o   <= 1'b0;
      end else if (busy_o) begin
        div_cnt <= half_tick ? '0 : div_cnt + DW'(1);
        if (half_tick) begin
          if (!sck_o) begin
            sck_o <= 1'b1;                      // rising: sample
            rx_o  <= {rx_o[6:0], miso_i};
          end else begin
            sck_o <= 1'b0;                      // falling: advance
            if (bit_cnt == 3'd7) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              sh      <= {sh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  a_r2_byte_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!sck_o && !busy_o));
  a_r2_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/flash_byte_mux.sv
`timescale 1ns/1ps
module flash_byte_mux
  import flash_seq_pkg::*;
(
  input  logic [CNT_W-1:0]  byte_idx,
  input  logic [7:0]        inst,
  input  logic              has_addr,
  input  logic              src_buf,
  input  logic              has_rx,
  input  logic [23:0]       addr,
  input  logic [7:0]        wsr,
  input  logic [31:0]       wbuf_word,
  output logic [7:0]        tx_byte,
  output logic [BUF_AW-1:0] wbuf_idx,
  output logic              in_rx
);
  logic [CNT_W-1:0] hl;
  logic [OFS_W-1:0] ofs;
  logic [1:0]       lane;

  assign hl       = hdr_len(has_addr);
  assign ofs      = OFS_W'(byte_idx - hl);
  assign wbuf_idx = ofs[OFS_W-1:2];
  assign lane     = ofs[1:0];
  assign in_rx    = has_rx && (byte_idx >= hl);

  always_comb begin
    if (byte_idx == '0) begin
      tx_byte = inst;
    end else if (byte_idx < hl) begin
      case (byte_idx[1:0])
        2'd1:    tx_byte = addr[23:16];
        2'd2:    tx_byte = addr[15:8];
        default: tx_byte = addr[7:0];
      endcase
    end else if (src_buf) begin
      case (lane)
        2'd0:    tx_byte = wbuf_word[31:24];
        2'd1:    tx_byte = wbuf_word[23:16];
        2'd2:    tx_byte = wbuf_word[15:8];
        default: tx_byte = wbuf_word[7:0];
      endcase
    end else if (!has_rx) begin
      tx_byte = wsr;
    end else begin
      tx_byte = 8'h00;
    end
  end
endmodule

// File: rtl/flash_op_sequencer.sv
`timescale 1ns/1ps
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [2:0]              op_code,
  input  logic [7:0]              op_page,
  input  logic [7:0]              op_sector,
  input  logic [7:0]              op_status_wr,
  output logic                    op_accept,
  output logic                    op_done,
  output logic [BUF_AW-1:0]       wbuf_idx,
  input  logic [31:0]             wbuf_word,
  output logic [8*READ_BYTES-1:0] rd_word,
  output logic [7:0]              status_byte,
  output logic                    spi_cs_n,
  output logic                    spi_sck,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_e;

  st_e              state;
  logic             wren_ph, inflight;
  logic [CNT_W-1:0] byte_idx, last_idx;
  logic [2:0]       code_q;
  logic [7:0]       page_q, sect_q, wsr_q;
  xfer_plan_t       cur_plan;
  logic             start_byte, shift_busy, shift_done, byte_in_rx, req_ok, last_byte;
  logic [7:0]       tx_byte, rx_byte;

  assign cur_plan   = wren_ph ? wren_plan() : main_plan(code_q);
  assign last_idx   = last_index(cur_plan);
  assign start_byte = (state == S_XFER) && !inflight;
  assign last_byte  = (byte_idx == last_idx);
  assign req_ok     = op_supported(op_code);
  assign spi_cs_n   = (state != S_XFER);

  flash_byte_mux u_mux (
    .byte_idx (byte_idx),
    .inst     (cur_plan.inst),
    .has_addr (cur_plan.has_addr),
    .src_buf  (cur_plan.src_buf),
    .has_rx   (cur_plan.n_in != '0),
    .addr     (flash_addr(sect_q, page_q)),
    .wsr      (wsr_q),
    .wbuf_word(wbuf_word),
    .tx_byte  (tx_byte),
    .wbuf_idx (wbuf_idx),
    .in_rx    (byte_in_rx)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_byte),
    .tx_i   (tx_byte),
    .miso_i (spi_miso),
    .sck_o  (spi_sck),
    .mosi_o (spi_mosi),
    .busy_o (shift_busy),
    .done_o (shift_done),
    .rx_o   (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      wren_ph     <= 1'b0;
      inflight    <= 1'b0;
      byte_idx    <= '0;
      code_q      <= '0;
      page_q      <= '0;
      sect_q      <= '0;
      wsr_q       <= '0;
      rd_word     <= '0;
      status_byte <= '0;
      op_accept   <= 1'b0;
      op_done     <= 1'b0;
    end else begin
      op_accept <= 1'b0;
      op_done   <= 1'b0;
      if (start_byte) inflight <= 1'b1;
      case (state)
        S_IDLE: if (op_valid) begin
          if (req_ok) begin
            code_q    <= op_code;
            page_q    <= op_page;
            sect_q    <= op_sector;
            wsr_q     <= op_status_wr;
            wren_ph   <= needs_wren(op_code);
            byte_idx  <= '0;
            op_accept <= 1'b1;
            state     <= S_XFER;
          end else begin
            op_done <= 1'b1;
          end
        end
        S_XFER: if (shift_done) begin
          inflight <= 1'b0;
          if (byte_in_rx) begin
            if (cur_plan.n_in == CNT_W'(1)) status_byte <= rx_byte;
            else rd_word <= {rd_word[8*READ_BYTES-9:0], rx_byte};
          end
          if (last_byte) begin
            if (wren_ph) state <= S_GAP;
            else begin
              state   <= S_IDLE;
              op_done <= 1'b1;
            end
          end else begin
            byte_idx <= byte_idx + CNT_W'(1);
          end
        end
        S_GAP: begin
          wren_ph  <= 1'b0;
          byte_idx <= '0;
          state    <= S_XFER;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_sck_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  a_r2_select_held_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    shift_busy |-> !spi_cs_n);
  a_r3_gap_after_wren: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_ph && shift_done && last_byte) |=> (spi_cs_n && !op_done) ##1 !spi_cs_n);
  a_r9_reserved_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && op_valid && !req_ok) |=> (op_done && !op_accept && spi_cs_n));
  a_r10_done_with_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> spi_cs_n);
  a_r10_accept_starts_bus: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |-> (!spi_cs_n && !op_done));
endmodule

// File: tb/flash_op_sequencer_tb_top.sv
`timescale 1ns/1ps
module flash_op_sequencer_tb_top;
  localparam int CLK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [7:0]  op_page = '0, op_sector = '0, op_status_wr = '0;
  logic        op_accept, op_done;
  logic [5:0]  wbuf_idx;
  logic [31:0] wbuf_word;
  logic [31:0] rd_word;
  logic [7:0]  status_byte;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

  int checks = 0;
  int fails  = 0;

  logic [31:0] bufw [0:63];
  int          mseed = 0;

  always #2.5 clk = ~clk;

  assign wbuf_word = bufw[wbuf_idx];

  flash_op_sequencer #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_page(op_page), .op_sector(op_sector), .op_status_wr(op_status_wr),
    .op_accept(op_accept), .op_done(op_done), .wbuf_idx(wbuf_idx),
    .wbuf_word(wbuf_word), .rd_word(rd_word), .status_byte(status_byte),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] miso_pat(input int n, input int seed);
    return 8'(n * 29 + seed) ^ 8'h5A;
  endfunction

  // flash responder: records bytes, answers with a seeded pattern
  int         bit_i = 0, byte_i = 0, ntr = 0;
  logic [7:0] cur = '0;
  logic [7:0] tbytes [0:3][0:263];
  int         tlen [0:3];
  logic [7:0] mb;

  always @(posedge spi_sck or negedge spi_cs_n) begin
    if (!spi_sck) begin
      bit_i  = 0;
      byte_i = 0;
    end else if (!spi_cs_n) begin
      cur = {cur[6:0], spi_mosi};
      bit_i++;
      if (bit_i == 8) begin
        if (byte_i < 264) tbytes[ntr & 3][byte_i] = cur;
        byte_i++;
        bit_i = 0;
      end
    end
  end

  always @(posedge spi_cs_n) begin
    tlen[ntr & 3] = byte_i;
    ntr++;
  end

  assign mb       = miso_pat(byte_i, mseed);
  assign spi_miso = spi_cs_n ? 1'b0 : mb[3'(7 - bit_i)];

  // serial clock shape monitor
  int   hi_run = 0, sck_bad = 0;
  logic sck_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n && spi_sck) sck_bad++;
      if (spi_sck) hi_run++;
      else begin
        if (sck_prev && hi_run != CLK_DIV / 2) sck_bad++;
        hi_run = 0;
      end
      sck_prev = spi_sck;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit two_phase(input logic [2:0] c);
    return c == 3'd1 || c == 3'd3 || c == 3'd5;
  endfunction

  function automatic int exp_len(input logic [2:0] c, input int t);
    if (two_phase(c) && t == 0) return 1;
    case (c)
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 260;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(input logic [2:0] c, input int t, input int i,
                                          input logic [7:0] pg, input logic [7:0] sc,
                                          input logic [7:0] ws);
    int d;
    if (two_phase(c) && t == 0) return 8'h06;
    if (i == 0) begin
      case (c)
        3'd1: return 8'hD8;
        3'd2: return 8'h03;
        3'd3: return 8'h02;
        3'd4: return 8'h05;
        default: return 8'h01;
      endcase
    end
    if (c == 3'd4) return 8'h00;
    if (c == 3'd5) return ws;
    if (i == 1) return sc;
    if (i == 2) return pg;
    if (i == 3) return 8'h00;
    if (c == 3'd2) return 8'h00;
    d = i - 4;
    return 8'(bufw[d >> 2] >> (8 * (3 - (d & 3))));
  endfunction

  function automatic string tag_of(input logic [2:0] c, input int t);
    if (two_phase(c) && t == 0) return "R3";
    case (c)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] c, input logic [7:0] pg, input logic [7:0] sc,
                        input logic [7:0] ws, input bit poke);
    int  base, cyc, accs, acc_cyc, nexp, slot, bad_i;
    bit  got_done, valid;
    logic [7:0] e;
    for (int i = 0; i < 64; i++) bufw[i] = $urandom;
    mseed = int'($urandom & 32'hFF);
    valid = (c >= 3'd1 && c <= 3'd5);
    base = ntr;
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_page = pg; op_sector = sc; op_status_wr = ws;
    accs = 0; acc_cyc = 0; cyc = 0; got_done = 0;
    while (!got_done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        op_valid = 1'b0;
        op_status_wr = ~ws;                       // later changes must not matter (R8)
      end
      if (op_accept) begin accs++; acc_cyc = cyc; end
      if (op_done) begin
        got_done = 1;
        chk(spi_cs_n == 1'b1, "R10 cs high at done", {31'd0, spi_cs_n}, 32'd1);
      end
      if (poke && cyc == 40) begin op_valid = 1'b1; op_code = 3'd4; end
      if (poke && cyc == 41) op_valid = 1'b0;
    end
    chk(got_done, "R10 done seen", {31'd0, got_done}, 32'd1);
    if (!valid) begin
      chk(cyc == 1 && accs == 0, "R9 immediate done, no accept", cyc, 1);
      repeat (5) @(negedge clk);
      chk(ntr == base && spi_cs_n, "R9 no bus activity", ntr - base, 0);
      return;
    end
    chk(accs == 1 && acc_cyc == 1, poke ? "R11 single accept while busy" : "R10 accept timing",
        acc_cyc, 1);
    nexp = two_phase(c) ? 2 : 1;
    chk(ntr - base == nexp, poke ? "R11 transaction count" : "R3 transaction count",
        ntr - base, nexp);
    for (int t = 0; t < nexp && t < ntr - base; t++) begin
      slot = (base + t) & 3;
      chk(tlen[slot] == exp_len(c, t), {tag_of(c, t), " length"}, tlen[slot], exp_len(c, t));
      bad_i = -1;
      for (int i = 0; i < exp_len(c, t) && i < tlen[slot] && i < 264; i++) begin
        e = exp_byte(c, t, i, pg, sc, ws);
        if (bad_i < 0 && tbytes[slot][i] !== e) bad_i = i;
      end
      if (bad_i < 0) chk(1'b1, tag_of(c, t), 0, 0);
      else chk(1'b0, {tag_of(c, t), " byte"}, {bad_i[15:0], 8'h00, tbytes[slot][bad_i]},
               {bad_i[15:0], 8'h00, exp_byte(c, t, bad_i, pg, sc, ws)});
    end
    if (c == 3'd2)
      chk(rd_word == {miso_pat(4, mseed), miso_pat(5, mseed), miso_pat(6, mseed), miso_pat(7, mseed)},
          "R5 packed read word", rd_word,
          {miso_pat(4, mseed), miso_pat(5, mseed), miso_pat(6, mseed), miso_pat(7, mseed)});
    if (c == 3'd4)
      chk(status_byte == miso_pat(1, mseed), "R7 status byte", {24'd0, status_byte},
          {24'd0, miso_pat(1, mseed)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int pp = 0;
    logic [2:0] c;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 64; i++) bufw[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && !op_accept && !op_done &&
        rd_word == '0 && status_byte == '0, "R1 reset state",
        {spi_cs_n, spi_sck, op_accept, op_done, rd_word[27:0]}, 32'h8000_0000);

    run_op(3'd0, 8'h11, 8'h22, 8'h33, 0);
    run_op(3'd6, 8'h11, 8'h22, 8'h33, 0);
    run_op(3'd7, 8'h11, 8'h22, 8'h33, 0);
    run_op(3'd1, 8'h00, 8'hFF, 8'h00, 0);
    run_op(3'd2, 8'hFF, 8'h00, 8'h00, 0);
    run_op(3'd3, 8'hA5, 8'h3C, 8'h00, 1);
    run_op(3'd4, 8'h00, 8'h00, 8'h00, 0);
    run_op(3'd5, 8'h00, 8'h00, 8'hA5, 0);
    run_op(3'd2, 8'h5A, 8'hC3, 8'h00, 0);
    for (int n = 0; n < 22; n++) begin
      c = 3'($urandom % 8);
      if (c == 3'd3) begin
        if (pp >= 3) c = 3'd2;
        else pp++;
      end
      run_op(c, 8'($urandom), 8'($urandom), 8'($urandom), 0);
    end
    chk(sck_bad == 0, "R2 serial clock shape", sck_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule